// File: doc/BRIEF.md
# Inverting Accumulator Port Transfer Unit

This block runs the port input and port output instructions of an 8-bit accumulator machine. The sequencer supplies an opcode and the current accumulator value with a one-cycle start pulse. The block decodes the instruction class and the port number from the opcode, and latches the port number at once. It then either writes the accumulator to the port bus or reads a byte from it. Data crossing between the accumulator and the pins is bitwise inverted in both directions.

After an input, the block updates the four status flags from the stored byte. The sign flag follows an inverted convention: it is set when the stored byte is non-negative. Two port numbers in each direction are not decoded, and those opcodes finish at once as short no-operations. A separate request clears the flags to a known state. A one-cycle `done` pulse marks the end of every instruction.

Top module: `acc_port_unit`

## Requirements
- R1: An opcode whose upper nibble is 0xA and whose lower nibble is not 2 or 3 is an input. The lower nibble (0, 1, 4 to 15) is driven on `port_addr`.
- R2: An opcode whose upper nibble is 0xB and whose lower nibble is not 2 or 3 is an output to the port given by the lower nibble.
- R3: Opcodes 0xA2, 0xA3, 0xB2, 0xB3 and every opcode of another class access no port. They pulse `done` in the cycle after start and leave the accumulator and the flags unchanged.
- R4: On input, `acc_out` receives the bitwise inverse of the byte sampled on `port_rdata`.
- R5: On output, `port_wdata` carries the bitwise inverse of the accumulator captured at start.
- R6: After an input, carry and overflow are 0, and zero is 1 exactly when the stored byte is 0x00.
- R7: After an input, sign is 1 when bit 7 of the stored byte is 0, and 0 when that bit is 1.
- R8: The port number is latched on the start edge. Later changes of `opcode` do not move `port_addr` while the instruction runs.
- R9: A `clr_flags` request, taken while idle and without start, sets zero and clears sign, carry and overflow in the next cycle.
- R10: An output instruction changes no flag, and `acc_out` keeps the accumulator value captured at start.
- R11: For an output, `port_we` is high for exactly the one cycle after the start edge, with address and data valid in it. `done` follows in the next cycle.
- R12: For an input, the address is valid from the start edge, `port_rdata` is sampled at the second edge after start, and the result and `done` appear after that edge.
- R13: Synchronous active-high reset clears all four flags, `done`, `port_we` and `acc_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to run `opcode` |
| opcode | input | 8 | Instruction byte |
| acc_in | input | 8 | Accumulator value at start |
| clr_flags | input | 1 | Clear-flags request |
| port_addr | output | 4 | Latched port number |
| port_wdata | output | 8 | Inverted accumulator for port writes |
| port_we | output | 1 | One-cycle port write strobe |
| port_rdata | input | 8 | Port read data |
| acc_out | output | 8 | Updated accumulator |
| flag_sign | output | 1 | Sign flag (set for non-negative) |
| flag_zero | output | 1 | Zero flag |
| flag_carry | output | 1 | Carry flag |
| flag_ovf | output | 1 | Overflow flag |
| done | output | 1 | Instruction complete pulse |

## Verification
The assertions check on every cycle that the write strobe lasts one cycle and carries the inverted accumulator. They also check the inversion on input, the flag values after an input or a clear, and that the address and the accumulator hold steady during a transfer. Only the bench scenarios can show that the decode is correct for the whole opcode range, including the undecoded port numbers. The same holds for a late opcode change leaving the latched port alone, for the exact latency of each instruction class, and for the state after reset.

// File: rtl/acc_io_pkg.sv
package acc_io_pkg;
   typedef enum logic [1:0] {
      XK_NONE  = 2'd0,
      XK_READ  = 2'd1,
      XK_WRITE = 2'd2
   } xfer_kind_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_XFER = 2'd1,
      ST_CAPT = 2'd2
   } xfer_state_t;
endpackage

// File: rtl/acc_io_decode.sv
module acc_io_decode
   import acc_io_pkg::*;
#(
   parameter int          OP_W         = 8,
   parameter int          PORT_AW      = 4,
   parameter logic [3:0]  IN_CLASS     = 4'hA,
   parameter logic [3:0]  OUT_CLASS    = 4'hB,
   parameter logic [15:0] BLOCKED_MASK = 16'h000C
) (
   input  logic [OP_W-1:0]    opcode,
   output xfer_kind_t         kind,
   output logic [PORT_AW-1:0] port_idx
);
   localparam int LOW_W = 4;

   if (OP_W != 8) begin : g_bad_opw
      $error("acc_io_decode: OP_W must be 8");
   end
   if (PORT_AW < LOW_W) begin : g_bad_aw
      $error("acc_io_decode: PORT_AW must be at least 4");
   end

   logic [LOW_W-1:0] low_nib;
   logic [LOW_W-1:0] cls_nib;
   logic             blocked;

   assign low_nib = opcode[LOW_W-1:0];
   assign cls_nib = opcode[OP_W-1:OP_W-LOW_W];
   assign blocked = BLOCKED_MASK[low_nib];

   if (PORT_AW == LOW_W) begin : g_idx_exact
      assign port_idx = low_nib;
   end else begin : g_idx_ext
      assign port_idx = {{(PORT_AW-LOW_W){1'b0}}, low_nib};
   end

   always_comb begin
      kind = XK_NONE;
      if (!blocked) begin
         if (cls_nib == IN_CLASS)       kind = XK_READ;
         else if (cls_nib == OUT_CLASS) kind = XK_WRITE;
      end
   end
endmodule

// File: rtl/acc_io_flags.sv
module acc_io_flags #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              upd,
   input  logic              clr,
   input  logic [DATA_W-1:0] val,
   output logic              flag_s,
   output logic              flag_z,
   output logic              flag_c,
   output logic              flag_o
);
   localparam int MSB = DATA_W - 1;

   if (DATA_W < 2) begin : g_bad_w
      $error("acc_io_flags: DATA_W must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         flag_s <= 1'b0;
         flag_z <= 1'b0;
         flag_c <= 1'b0;
         flag_o <= 1'b0;
      end else if (upd) begin
         flag_s <= ~val[MSB];
         flag_z <= (val == '0);
         flag_c <= 1'b0;
         flag_o <= 1'b0;
      end else if (clr) begin
         flag_s <= 1'b0;
         flag_z <= 1'b1;
         flag_c <= 1'b0;
         flag_o <= 1'b0;
      end
   end

   // R6: carry and overflow cleared by an input
   p_in_co_r6: assert property (@(posedge clk) disable iff (rst)
      upd |=> (!flag_c && !flag_o));
   // R6: zero reflects the stored byte
   p_in_zero_r6: assert property (@(posedge clk) disable iff (rst)
      upd |=> (flag_z == ($past(val) == '0)));
   // R7: sign is set for a clear top bit
   p_in_sign_r7: assert property (@(posedge clk) disable iff (rst)
      upd |=> (flag_s == !$past(val[MSB])));
   // R9: clear request result
   p_clr_r9: assert property (@(posedge clk) disable iff (rst)
      (clr && !upd) |=> (flag_z && !flag_s && !flag_c && !flag_o));
endmodule

// File: rtl/acc_port_unit.sv
module acc_port_unit
   import acc_io_pkg::*;
#(
   parameter int          DATA_W       = 8,
   parameter int          OP_W         = 8,
   parameter int          PORT_AW      = 4,
   parameter bit          PIN_INVERT   = 1'b1,
   parameter logic [15:0] BLOCKED_MASK = 16'h000C
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               start,
   input  logic [OP_W-1:0]    opcode,
   input  logic [DATA_W-1:0]  acc_in,
   input  logic               clr_flags,
   output logic [PORT_AW-1:0] port_addr,
   output logic [DATA_W-1:0]  port_wdata,
   output logic               port_we,
   input  logic [DATA_W-1:0]  port_rdata,
   output logic [DATA_W-1:0]  acc_out,
   output logic               flag_sign,
   output logic               flag_zero,
   output logic               flag_carry,
   output logic               flag_ovf,
   output logic               done
);
   xfer_state_t        state;
   xfer_kind_t         dec_kind;
   xfer_kind_t         kind_q;
   logic [PORT_AW-1:0] dec_idx;
   logic [PORT_AW-1:0] idx_q;
   logic [DATA_W-1:0]  acc_q;
   logic [DATA_W-1:0]  from_pins;
   logic               accept;
   logic               capt;
   logic               clr_req;

   acc_io_decode #(
      .OP_W(OP_W), .PORT_AW(PORT_AW), .BLOCKED_MASK(BLOCKED_MASK)
   ) u_dec (
      .opcode(opcode), .kind(dec_kind), .port_idx(dec_idx)
   );

   if (PIN_INVERT) begin : g_inv
      assign from_pins  = ~port_rdata;
      assign port_wdata = ~acc_q;
   end else begin : g_pass
      assign from_pins  = port_rdata;
      assign port_wdata = acc_q;
   end

   assign accept  = (state == ST_IDLE) && start;
   assign capt    = (state == ST_CAPT);
   assign clr_req = (state == ST_IDLE) && !start && clr_flags;

   always_ff @(posedge clk) begin
      if (rst) begin
         state  <= ST_IDLE;
         kind_q <= XK_NONE;
         idx_q  <= '0;
         acc_q  <= '0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: if (start) begin
               acc_q  <= acc_in;
               kind_q <= dec_kind;
               if (dec_kind == XK_NONE) begin
                  done <= 1'b1;
               end else begin
                  idx_q <= dec_idx;
                  state <= ST_XFER;
               end
            end
            ST_XFER: begin
               if (kind_q == XK_WRITE) begin
                  done  <= 1'b1;
                  state <= ST_IDLE;
               end else begin
                  state <= ST_CAPT;
               end
            end
            ST_CAPT: begin
               acc_q <= from_pins;
               done  <= 1'b1;
               state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign port_addr = idx_q;
   assign port_we   = (state == ST_XFER) && (kind_q == XK_WRITE);
   assign acc_out   = acc_q;

   acc_io_flags #(.DATA_W(DATA_W)) u_flags (
      .clk(clk), .rst(rst), .upd(capt), .clr(clr_req), .val(from_pins),
      .flag_s(flag_sign), .flag_z(flag_zero), .flag_c(flag_carry), .flag_o(flag_ovf)
   );

   // R11: write strobe lasts one cycle and is followed by done
   p_we_single_r11: assert property (@(posedge clk) disable iff (rst)
      port_we |=> (!port_we && done));
   // R10: output leaves accumulator and flags alone
   p_out_hold_r10: assert property (@(posedge clk) disable iff (rst)
      port_we |=> ($stable(acc_out) && $stable(flag_sign) && $stable(flag_zero)));
   // R8: address held across the transfer
   p_addr_hold_r8: assert property (@(posedge clk) disable iff (rst)
      capt |-> $stable(port_addr));
   // R3: undecoded opcodes finish at once without a strobe
   p_nop_done_r3: assert property (@(posedge clk) disable iff (rst)
      (accept && dec_kind == XK_NONE) |=> (done && !port_we));

   if (PIN_INVERT) begin : g_inv_chk
      // R5: write data is the inverted accumulator
      p_wdata_inv_r5: assert property (@(posedge clk) disable iff (rst)
         port_we |-> (port_wdata == ~acc_out));
      // R4: input stores the inverted bus byte
      p_in_inv_r4: assert property (@(posedge clk) disable iff (rst)
         capt |=> (acc_out == ~$past(port_rdata)));
   end
endmodule

// File: tb/tb_acc_port_unit.sv
module tb_acc_port_unit;
   logic       clk = 1'b0;
   logic       rst;
   logic       start;
   logic [7:0] opcode;
   logic [7:0] acc_in;
   logic       clr_flags;
   logic [3:0] port_addr;
   logic [7:0] port_wdata;
   logic       port_we;
   logic [7:0] port_rdata;
   logic [7:0] acc_out;
   logic       flag_sign, flag_zero, flag_carry, flag_ovf, done;

   int checks = 0;
   int fails  = 0;
   string tag = "R13";

   always #4 clk = ~clk;

   acc_port_unit dut (
      .clk(clk), .rst(rst), .start(start), .opcode(opcode), .acc_in(acc_in),
      .clr_flags(clr_flags), .port_addr(port_addr), .port_wdata(port_wdata),
      .port_we(port_we), .port_rdata(port_rdata), .acc_out(acc_out),
      .flag_sign(flag_sign), .flag_zero(flag_zero), .flag_carry(flag_carry),
      .flag_ovf(flag_ovf), .done(done)
   );

   // behavioural reference: a countdown of remaining transfer cycles
   int         m_left = 0;
   bit         m_read = 0;
   logic [3:0] m_port = 0;
   logic [7:0] m_acc = 0;
   logic       m_s = 0, m_z = 0, m_c = 0, m_o = 0, m_done = 0;

   always @(posedge clk) begin
      m_done <= 1'b0;
      if (rst) begin
         m_left <= 0; m_acc <= 8'h00; m_port <= 4'h0;
         m_s <= 0; m_z <= 0; m_c <= 0; m_o <= 0;
      end else if (m_left == 0) begin
         if (start) begin
            m_acc <= acc_in;
            if ((opcode[7:4] == 4'hA || opcode[7:4] == 4'hB) &&
                opcode[3:0] != 4'd2 && opcode[3:0] != 4'd3) begin
               m_read <= (opcode[7:4] == 4'hA);
               m_port <= opcode[3:0];
               m_left <= (opcode[7:4] == 4'hA) ? 2 : 1;
            end else begin
               m_done <= 1'b1;
            end
         end else if (clr_flags) begin
            m_s <= 0; m_z <= 1; m_c <= 0; m_o <= 0;
         end
      end else begin
         m_left <= m_left - 1;
         if (m_left == 1) begin
            m_done <= 1'b1;
            if (m_read) begin
               m_acc <= port_rdata ^ 8'hFF;
               m_s <= ~port_rdata[7] ? 1'b0 : 1'b1;
               m_z <= (port_rdata == 8'hFF);
               m_c <= 0; m_o <= 0;
            end
         end
      end
   end

   task automatic chk(input string t, input string what, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", t, what, act, exp, $time);
      end
   endtask

   logic exp_we;
   always @(negedge clk) begin
      exp_we = (m_left == 1) && !m_read;
      chk(tag, "acc_out", acc_out, m_acc);
      chk(tag, "flags{s,z,c,o}", {4'h0, flag_sign, flag_zero, flag_carry, flag_ovf},
          {4'h0, m_s, m_z, m_c, m_o});
      chk(tag, "done", {7'h0, done}, {7'h0, m_done});
      chk(tag, "port_we", {7'h0, port_we}, {7'h0, exp_we});
      if (m_left != 0) chk({tag, "/R8"}, "port_addr", {4'h0, port_addr}, {4'h0, m_port});
      if (exp_we) chk({tag, "/R5"}, "port_wdata", port_wdata, m_acc ^ 8'hFF);
   end

   task automatic run_op(input string t, input logic [7:0] op, input logic [7:0] a, input logic [7:0] rd);
      tag = t;
      @(negedge clk);
      opcode = op; acc_in = a; port_rdata = rd; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      opcode = 8'h0F;   // R8: later opcode change must not move the port
      acc_in = ~a;
      repeat (4) @(negedge clk);
   endtask

   task automatic do_clear(input string t);
      tag = t;
      @(negedge clk);
      clr_flags = 1'b1;
      @(negedge clk);
      clr_flags = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      rst = 1'b1; start = 0; opcode = 0; acc_in = 0; clr_flags = 0; port_rdata = 0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      tag = "R13";
      @(negedge clk);
      run_op("R1/R4/R7", 8'hA0, 8'h11, 8'h3C);   // stores C3, sign 0
      run_op("R1/R6/R7", 8'hA1, 8'h22, 8'hFF);   // stores 00, zero 1, sign 1
      run_op("R1/R4/R12", 8'hA7, 8'h00, 8'h80);  // stores 7F, sign 1
      run_op("R1/R12", 8'hAF, 8'h55, 8'h00);     // stores FF
      do_clear("R9");
      run_op("R2/R5/R11", 8'hB0, 8'h5A, 8'h00);
      run_op("R2/R10", 8'hB1, 8'h80, 8'h12);
      run_op("R2/R5/R8", 8'hB9, 8'hC3, 8'h00);
      run_op("R2/R11", 8'hBF, 8'h01, 8'h00);
      run_op("R3", 8'hA2, 8'h77, 8'h00);
      run_op("R3", 8'hA3, 8'h66, 8'h00);
      run_op("R3", 8'hB2, 8'h44, 8'h00);
      run_op("R3", 8'hB3, 8'h33, 8'h00);
      run_op("R3", 8'h29, 8'h99, 8'h00);
      run_op("R6/R7", 8'hA5, 8'h00, 8'h01);      // stores FE
      for (int p = 4; p < 16; p++) begin
         run_op("R1", {4'hA, p[3:0]}, 8'h00, p[7:0]);
         run_op("R2", {4'hB, p[3:0]}, p[7:0], 8'h00);
      end
      @(negedge clk);
      rst = 1'b1;
      tag = "R13";
      repeat (2) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule